// File: doc/BRIEF.md
# Image Sensor Power-Up Reset Sequencer

This block brings an image sensor out of its power-on reset in a fixed order. While the supply is not yet good, it holds the sensor in reset. Once a power-good flag is high and a start request arrives, it keeps an active-low reset line low for a minimum pulse length. It then releases that line and counts a settling interval. When the interval ends, it raises a settled flag. The same reset level is driven onto two clear lines, one for the horizontal shift register and one for the vertical shift register.

A serial-ready output opens the way for the downstream configuration interface. It only rises after the reset line is already high, so no configuration word can reach the sensor while the sensor is still in reset.

The pulse and settle lengths are given as a clock frequency in kHz and durations in microseconds. They are converted to whole clock cycles by rounding up, so the minimum durations are never cut short. The power-good input also serves as the block's asynchronous reset: dropping it at any point returns the whole sequence to its starting state.

Top module: `sensor_reset_seq`

## Requirements
- R1: While `pwrGood` is 0, `rstN`, `hClrN`, `vClrN`, `serialReady` and `settleDone` are all 0. A fall of `pwrGood` forces them to 0 at once, without waiting for a clock edge.
- R2: With `pwrGood` high and the block idle, a rising clock edge that samples `startReq` high accepts the start. `rstN` stays 0 from reset until exactly PULSE_CYC+1 rising edges after the accepting edge, and then goes to 1.
- R3: `hClrN` and `vClrN` carry the same level as `rstN` in every cycle.
- R4: `serialReady` rises exactly one cycle after `rstN` rises, and it is never 1 while `rstN` is 0.
- R5: `settleDone` rises exactly SETTLE_CYC cycles after `rstN` rises. It then stays at 1 until `pwrGood` falls.
- R6: Once a start has been accepted, further values on `startReq` have no effect on any output until `pwrGood` falls.
- R7: PULSE_CYC = ceil(CLK_KHZ*PULSE_US/1000) and SETTLE_CYC = ceil(CLK_KHZ*SETTLE_US/1000), each with a floor of 1. For example, 1500 kHz and 7 us give 11 cycles, and 1500 kHz and 300 us give 450 cycles.
- R8: After `pwrGood` returns high, the block stays idle with all outputs at 0 until a new `startReq` is sampled. A `startReq` that is already high when `pwrGood` rises is accepted on the first edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| pwrGood | input | 1 | Supply above the power-on threshold; 0 acts as an asynchronous reset |
| startReq | input | 1 | Request to begin the reset-then-settle sequence |
| rstN | output | 1 | Active-low sensor reset |
| hClrN | output | 1 | Active-low horizontal shift-register clear, same level as rstN |
| vClrN | output | 1 | Active-low vertical shift-register clear, same level as rstN |
| settleDone | output | 1 | Settling interval complete (sticky) |
| serialReady | output | 1 | Downstream configuration interface may send data |

## Verification
Two events can coincide with each other. The first is a loss of power-good. The second is either a start being accepted or the reset release, since both of these are edge-timed events. A drop that lands in the very cycle where `rstN` would rise must still leave every output at 0. The same holds for a drop in the cycle where `settleDone` would rise.

The bench provokes these cases in two ways. It drops power at randomly chosen points that include the pulse and settle boundaries. It also raises power-good while `startReq` is already held high. A cycle-count model in the bench judges every output on every cycle. It also checks that the outputs are forced to 0 immediately after each drop, before the next clock edge.

// File: rtl/rst_seq_pkg.sv
`timescale 1ns/1ps
package rst_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PULSE  = 2'd1,
    ST_SETTLE = 2'd2,
    ST_READY  = 2'd3
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic relRst;
    logic settled;
  } seqStrb_t;

  // Duration in microseconds to whole cycles, rounded up, at least one
  function automatic int ceilCycles(input int clkKhz, input int durUs);
    longint prod;
    longint cyc;
    prod = longint'(clkKhz) * longint'(durUs);
    cyc  = (prod + 64'd999) / 64'd1000;
    if (cyc < 1) cyc = 1;
    return int'(cyc);
  endfunction

endpackage

// File: rtl/rst_seq_ctrl.sv
`timescale 1ns/1ps
module rst_seq_ctrl
  import rst_seq_pkg::*;
(
  input  logic     clk,
  input  logic     pwrGood,
  input  logic     startReq,
  input  logic     pulseHit,
  input  logic     settleHit,
  output seqStrb_t strb
);

  seqState_t state, stateNxt;

  always_ff @(posedge clk or negedge pwrGood) begin
    if (!pwrGood) state <= ST_IDLE;
    else          state <= stateNxt;
  end

  always_comb begin
    stateNxt     = state;
    strb.cntClr  = 1'b0;
    strb.cntInc  = 1'b0;
    strb.relRst  = 1'b0;
    strb.settled = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          stateNxt    = ST_PULSE;
          strb.cntClr = 1'b1;
        end
      end
      ST_PULSE: begin
        strb.cntInc = 1'b1;
        if (pulseHit) begin
          stateNxt    = ST_SETTLE;
          strb.cntClr = 1'b1;
        end
      end
      ST_SETTLE: begin
        strb.cntInc = 1'b1;
        strb.relRst = 1'b1;
        if (settleHit) stateNxt = ST_READY;
      end
      ST_READY: begin
        strb.relRst  = 1'b1;
        strb.settled = 1'b1;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/rst_seq_dpath.sv
`timescale 1ns/1ps
module rst_seq_dpath
  import rst_seq_pkg::*;
#(
  parameter int PULSE_CYC  = 11,
  parameter int SETTLE_CYC = 450
) (
  input  logic     clk,
  input  logic     pwrGood,
  input  seqStrb_t strb,
  output logic     pulseHit,
  output logic     settleHit,
  output logic     rstQ,
  output logic     serQ,
  output logic     doneQ
);

  localparam int MAX_CYC = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge pwrGood) begin
    if (!pwrGood)         cnt <= '0;
    else if (strb.cntClr) cnt <= '0;
    else if (strb.cntInc) cnt <= cnt + 1'b1;
  end

  assign pulseHit  = (cnt == CNT_W'(PULSE_CYC - 1));
  assign settleHit = (cnt == CNT_W'(SETTLE_CYC - 1));

  // Registered outputs; serial enable trails the reset release by a cycle
  always_ff @(posedge clk or negedge pwrGood) begin
    if (!pwrGood) begin
      rstQ  <= 1'b0;
      serQ  <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      rstQ  <= strb.relRst;
      serQ  <= rstQ;
      doneQ <= strb.settled;
    end
  end

endmodule

// File: rtl/sensor_reset_seq.sv
`timescale 1ns/1ps
module sensor_reset_seq
  import rst_seq_pkg::*;
#(
  parameter int CLK_KHZ   = 125000,
  parameter int PULSE_US  = 100,
  parameter int SETTLE_US = 10000
) (
  input  logic clk,
  input  logic pwrGood,
  input  logic startReq,
  output logic rstN,
  output logic hClrN,
  output logic vClrN,
  output logic settleDone,
  output logic serialReady
);

  localparam int PULSE_CYC  = ceilCycles(CLK_KHZ, PULSE_US);
  localparam int SETTLE_CYC = ceilCycles(CLK_KHZ, SETTLE_US);

  seqStrb_t strb;
  logic     pulseHit, settleHit;
  logic     rstQ, serQ, doneQ;

  rst_seq_ctrl u_ctrl (
    .clk       (clk),
    .pwrGood   (pwrGood),
    .startReq  (startReq),
    .pulseHit  (pulseHit),
    .settleHit (settleHit),
    .strb      (strb)
  );

  rst_seq_dpath #(
    .PULSE_CYC  (PULSE_CYC),
    .SETTLE_CYC (SETTLE_CYC)
  ) u_dpath (
    .clk       (clk),
    .pwrGood   (pwrGood),
    .strb      (strb),
    .pulseHit  (pulseHit),
    .settleHit (settleHit),
    .rstQ      (rstQ),
    .serQ      (serQ),
    .doneQ     (doneQ)
  );

  assign rstN        = rstQ;
  assign hClrN       = rstQ;
  assign vClrN       = rstQ;
  assign serialReady = serQ;
  assign settleDone  = doneQ;

endmodule

// File: rtl/rst_seq_chk.sv
`timescale 1ns/1ps
module rst_seq_chk #(
  parameter int PULSE_CYC  = 11,
  parameter int SETTLE_CYC = 450
) (
  input logic clk,
  input logic pwrGood,
  input logic rstN,
  input logic hClrN,
  input logic vClrN,
  input logic serialReady,
  input logic settleDone
);

  logic [31:0] lowCnt, highCnt;

  always_ff @(posedge clk or negedge pwrGood) begin
    if (!pwrGood) begin
      lowCnt  <= '0;
      highCnt <= '0;
    end else begin
      if (!rstN && lowCnt  != 32'hFFFF_FFFF) lowCnt  <= lowCnt + 1;
      if ( rstN && highCnt != 32'hFFFF_FFFF) highCnt <= highCnt + 1;
    end
  end

  AST_DOWN_QUIET: assert property (@(negedge clk)
    !pwrGood |-> (!rstN && !hClrN && !vClrN && !serialReady && !settleDone)); // R1

  AST_PULSE_MIN: assert property (@(posedge clk) disable iff (!pwrGood)
    $rose(rstN) |-> (lowCnt >= 32'(PULSE_CYC))); // R2

  AST_CLR_MATCH: assert property (@(posedge clk) disable iff (!pwrGood)
    (hClrN == rstN) && (vClrN == rstN)); // R3

  AST_SER_GATED: assert property (@(posedge clk) disable iff (!pwrGood)
    serialReady |-> rstN); // R4

  AST_SER_LAG: assert property (@(posedge clk) disable iff (!pwrGood)
    $rose(rstN) |=> serialReady); // R4

  AST_SETTLE_MIN: assert property (@(posedge clk) disable iff (!pwrGood)
    $rose(settleDone) |-> (highCnt >= 32'(SETTLE_CYC))); // R5

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!pwrGood)
    settleDone |=> settleDone); // R5

endmodule

bind sensor_reset_seq rst_seq_chk #(
  .PULSE_CYC  (PULSE_CYC),
  .SETTLE_CYC (SETTLE_CYC)
) u_chk (
  .clk         (clk),
  .pwrGood     (pwrGood),
  .rstN        (rstN),
  .hClrN       (hClrN),
  .vClrN       (vClrN),
  .serialReady (serialReady),
  .settleDone  (settleDone)
);

// File: tb/test_sensor_reset_seq.sv
`timescale 1ns/1ps
module test_sensor_reset_seq;

  localparam int TB_KHZ    = 1500;
  localparam int TB_PUL_US = 7;
  localparam int TB_SET_US = 300;

  logic clk = 1'b0;
  logic pwrGood, startReq;
  logic rstN, hClrN, vClrN, settleDone, serialReady;

  int nChecks = 0;
  int nFail   = 0;
  bit started = 0;
  int n       = 0;
  bit finished = 0;

  function automatic int expCyc(input int khz, input int us);
    int c;
    c = (khz * us + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int P = expCyc(TB_KHZ, TB_PUL_US);
  localparam int S = expCyc(TB_KHZ, TB_SET_US);

  always #4 clk = ~clk;  // 125 MHz

  sensor_reset_seq #(
    .CLK_KHZ   (TB_KHZ),
    .PULSE_US  (TB_PUL_US),
    .SETTLE_US (TB_SET_US)
  ) i_sensor_reset_seq (
    .clk         (clk),
    .pwrGood     (pwrGood),
    .startReq    (startReq),
    .rstN        (rstN),
    .hClrN       (hClrN),
    .vClrN       (vClrN),
    .settleDone  (settleDone),
    .serialReady (serialReady)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s t=%0t act=%0b exp=%0b", tag, $time, act, exp);
    end
  endtask

  task automatic chkInt(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s t=%0t act=%0d exp=%0d", tag, $time, act, exp);
    end
  endtask

  function automatic logic eRst();  return started && (n >= P + 1);     endfunction
  function automatic logic eSer();  return started && (n >= P + 2);     endfunction
  function automatic logic eDone(); return started && (n >= P + S + 1); endfunction

  task automatic compareAll(input string rstTag);
    chk(rstTag, rstN, eRst());
    chk("R3 hClrN", hClrN, eRst());
    chk("R3 vClrN", vClrN, eRst());
    chk("R4 serialReady", serialReady, eSer());
    chk("R5 settleDone", settleDone, eDone());
  endtask

  // One clock: model advances at the edge, outputs judged at the next negedge
  task automatic cyc(input string rstTag);
    @(posedge clk);
    if (!pwrGood) started = 0;
    else if (started) begin
      if (n < 1000000) n++;
    end else if (startReq) begin
      started = 1;
      n = 0;
    end
    @(negedge clk);
    compareAll(rstTag);
  endtask

  task automatic dropPower(input int lowCycles);
    pwrGood = 1'b0;
    started = 0;
    #1;
    chk("R1 rstN", rstN, 1'b0);
    chk("R1 hClrN", hClrN, 1'b0);
    chk("R1 vClrN", vClrN, 1'b0);
    chk("R1 serialReady", serialReady, 1'b0);
    chk("R1 settleDone", settleDone, 1'b0);
    @(negedge clk);
    for (int i = 0; i < lowCycles; i++) begin
      startReq = 1'($urandom_range(0, 1));
      cyc("R1 rstN");
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    pwrGood  = 1'b0;
    startReq = 1'b0;
    repeat (3) @(negedge clk);
    compareAll("R1 rstN");

    // R7: cycle conversion rounds up
    chkInt("R7 pulse cycles", P, 11);
    chkInt("R7 settle cycles", S, 450);

    // R8: idle until a start is seen
    pwrGood = 1'b1;
    for (int i = 0; i < 6; i++) cyc("R8 rstN");
    startReq = 1'b1;
    cyc("R2 rstN");
    startReq = 1'b0;
    begin
      int k = 0;
      while (rstN !== 1'b1 && k < 200) begin
        cyc("R2 rstN");
        k++;
      end
      chkInt("R2 pulse length", k, P + 1);
    end
    // R6: start toggling while settling and after done
    for (int i = 0; i < S + 60; i++) begin
      startReq = 1'($urandom_range(0, 1));
      cyc("R6 rstN");
    end
    startReq = 1'b0;

    // Drop exactly at the release cycle and at the done cycle
    dropPower(2);
    startReq = 1'b1;             // R8: already high when power returns
    pwrGood  = 1'b1;
    cyc("R8 rstN");
    startReq = 1'b0;
    for (int i = 0; i < P; i++) cyc("R2 rstN");
    dropPower(1);                // rstN was about to rise
    pwrGood = 1'b1;
    startReq = 1'b1;
    cyc("R2 rstN");
    startReq = 1'b0;
    for (int i = 0; i < P + S; i++) cyc("R5 rstN");
    dropPower(3);                // settleDone was about to rise

    // Random power-up sessions
    for (int it = 0; it < 14; it++) begin
      int idle, runLen;
      pwrGood = 1'b1;
      idle = $urandom_range(0, 12);
      startReq = 1'b0;
      for (int i = 0; i < idle; i++) cyc("R8 rstN");
      startReq = 1'b1;
      for (int i = 0; i < int'($urandom_range(1, 3)); i++) cyc("R2 rstN");
      runLen = $urandom_range(0, P + S + 40);
      for (int i = 0; i < runLen; i++) begin
        startReq = 1'($urandom_range(0, 1));
        cyc("R6 rstN");
      end
      startReq = 1'b0;
      dropPower($urandom_range(1, 5));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired t=%0t", $time);
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

endmodule